// File: doc/BRIEF.md
# Fractional Clock-Rate Controller

This block thins a parent clock into an enable stream. The average enable rate is the parent rate times N/32, with N running from 1 to 32. No derived clock exists. Logic in the parent domain qualifies its registers with the enable, so the unwanted cycles are swallowed instead of gated. Software programs a 5-bit slow-down code and then requests the change with a self-clearing trigger bit.

The code is stored as 32 minus the wanted multiplier, so a code of 0 means full rate and a code of 31 means one enable in every 32 cycles. Writing the code only stages it. The running ratio moves to the staged value after a trigger, at the next boundary of a free-running 32-cycle window. The trigger bit then returns to 0 by itself. A fractional accumulator spreads the enables through each window, and every aligned window carries exactly N of them.

Top module: `frac_clk_ctrl`

## Requirements
- R1: After reset, both registers read 0, the trigger bit reads 0, and the enable is high in every cycle (full rate).
- R2: In every aligned 32-cycle window (windows start at the first rising edge after reset is released), the enable is high in exactly 32 − Z cycles, where Z is the running code.
- R3: The code register at byte offset 0xE0 holds the staged code Z in bits [12:8]. All 32 bits of that register are read/write storage and read back as written.
- R4: A write to byte offset 0x04 with bit 31 = 1, while the trigger bit is 0, sets the trigger bit. It reads back as bit 31 of offset 0x04 from the next cycle. All other bits of that register read 0.
- R5: The trigger bit clears by itself at the end of the window in which it is pending, so it stays high for at most 32 cycles. It is first seen low in phase 0 of a window. From that window on, the running code equals the staged code.
- R6: Writing the code register without a trigger leaves the enable pattern unchanged.
- R7: A write to offset 0x04 with bit 31 = 0 has no effect. A write with bit 31 = 1 while the trigger bit is already 1 is ignored and does not move the clearing point.
- R8: The read data is 0 when the read strobe is low or the address is neither 0x04 nor 0xE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | 12 | Byte address of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data (combinational) |
| clkEn | output | 1 | Per-cycle enable qualifier |
| kickBusy | output | 1 | Trigger bit, high while a ratio change is pending |

## Verification
The assertions assume the register strobes are clean, single-cycle, known values. They also assume the window phase starts from reset, so every counted window is aligned. The bench drives every access on the falling edge, holds each write strobe for exactly one cycle, and never overlaps a read with a write. It rewrites the code while a change is pending only in the way software would: it retriggers, and it does not alter the staged value mid-change.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
  // strobes from the register/control side to the rate datapath
  typedef struct packed {
    logic loadRatio;   // copy staged code into running code this edge
    logic busy;        // change pending
  } ctrlStrobe_t;
endpackage

// File: rtl/frac_clk_regs.sv
module frac_clk_regs
  import frac_clk_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int ZF_W     = 5,
  parameter int ZF_LSB   = 8,
  parameter int CTRL_OFS = 'hE0,
  parameter int KICK_OFS = 'h04,
  parameter int KICK_BIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              periodEnd,
  output logic [DATA_W-1:0] regRdata,
  output logic [ZF_W-1:0]   stagedZfc,
  output ctrlStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] KickAddr = ADDR_W'(KICK_OFS);

  logic [DATA_W-1:0] ctrlReg;
  logic              busyQ;
  logic              hitCtrl;
  logic              hitKick;
  logic              kickReq;
  logic              loadNow;

  assign hitCtrl = (regAddr == CtrlAddr);
  assign hitKick = (regAddr == KickAddr);
  assign kickReq = regWr && hitKick && regWdata[KICK_BIT];
  assign loadNow = busyQ && periodEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (regWr && hitCtrl) begin
      ctrlReg <= regWdata;
    end
  end

  // trigger: set on request when idle, cleared at window end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
    end else if (loadNow) begin
      busyQ <= 1'b0;
    end else if (kickReq && !busyQ) begin
      busyQ <= 1'b1;
    end
  end

  assign stagedZfc        = ctrlReg[ZF_LSB +: ZF_W];
  assign strobe.loadRatio = loadNow;
  assign strobe.busy      = busyQ;

  always_comb begin
    regRdata = '0;
    if (regRd) begin
      if (hitCtrl) begin
        regRdata = ctrlReg;
      end else if (hitKick) begin
        regRdata[KICK_BIT] = busyQ;
      end
    end
  end
endmodule

// File: rtl/frac_clk_datapath.sv
module frac_clk_datapath
  import frac_clk_pkg::*;
#(
  parameter int ZF_W = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [ZF_W-1:0] stagedZfc,
  output logic [ZF_W-1:0] activeZfc,
  output logic            periodEnd,
  output logic            clkEn
);
  localparam int DEN = 1 << ZF_W;          // window length
  localparam int MW  = ZF_W + 1;           // multiplier width
  localparam int SW  = ZF_W + 2;           // sum width

  logic [ZF_W-1:0] phase;
  logic [ZF_W-1:0] acc;
  logic [MW-1:0]   mult;
  logic [SW-1:0]   sum;
  logic            carry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  assign periodEnd = (phase == ZF_W'(DEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeZfc <= '0;
    end else if (strobe.loadRatio) begin
      activeZfc <= stagedZfc;
    end
  end

  assign mult  = MW'(DEN) - MW'(activeZfc);
  assign sum   = SW'(acc) + SW'(mult);
  assign carry = (sum >= SW'(DEN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (carry) begin
      acc <= ZF_W'(sum - SW'(DEN));
    end else begin
      acc <= ZF_W'(sum);
    end
  end

  assign clkEn = carry;
endmodule

// File: rtl/frac_clk_ctrl.sv
module frac_clk_ctrl
  import frac_clk_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int ZF_W     = 5,
  parameter int ZF_LSB   = 8,
  parameter int CTRL_OFS = 'hE0,
  parameter int KICK_OFS = 'h04,
  parameter int KICK_BIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              clkEn,
  output logic              kickBusy
);
  ctrlStrobe_t     strobe;
  logic [ZF_W-1:0] stagedZfc;
  logic [ZF_W-1:0] activeZfc;
  logic            periodEnd;

  frac_clk_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZF_W(ZF_W), .ZF_LSB(ZF_LSB),
    .CTRL_OFS(CTRL_OFS), .KICK_OFS(KICK_OFS), .KICK_BIT(KICK_BIT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .periodEnd(periodEnd),
    .regRdata(regRdata), .stagedZfc(stagedZfc), .strobe(strobe)
  );

  frac_clk_datapath #(.ZF_W(ZF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stagedZfc(stagedZfc),
    .activeZfc(activeZfc), .periodEnd(periodEnd), .clkEn(clkEn)
  );

  assign kickBusy = strobe.busy;
endmodule

// File: rtl/frac_clk_checker.sv
module frac_clk_checker #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int ZF_W     = 5,
  parameter int KICK_OFS = 'h04,
  parameter int KICK_BIT = 31
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              clkEn,
  input logic              kickBusy,
  input logic              periodEnd,
  input logic              loadRatio,
  input logic [ZF_W-1:0]   activeZfc
);
  localparam int DEN = 1 << ZF_W;

  logic [ZF_W:0] winCnt;
  logic [ZF_W:0] busyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (periodEnd) begin
      winCnt <= '0;
    end else begin
      winCnt <= winCnt + (ZF_W+1)'(clkEn);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (kickBusy) begin
      busyCnt <= busyCnt + 1'b1;
    end else begin
      busyCnt <= '0;
    end
  end

  // R2: window enable count matches running code
  p_window_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |-> ((winCnt + (ZF_W+1)'(clkEn)) == ((ZF_W+1)'(DEN) - (ZF_W+1)'(activeZfc))));

  // R5: trigger pending at window end clears on the next edge
  p_kick_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (kickBusy && periodEnd) |=> !kickBusy);

  // R5: bounded pending time
  p_busy_bounded_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= (ZF_W+1)'(DEN));

  // R6: running code moves only on a load
  p_active_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !loadRatio |=> $stable(activeZfc));

  // R7: trigger write with bit clear does not set busy
  p_kick_zero_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!kickBusy && regWr && regAddr == ADDR_W'(KICK_OFS) && !regWdata[KICK_BIT]) |=> !kickBusy);

  // R4: idle trigger write with bit set starts a change
  p_kick_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!kickBusy && regWr && regAddr == ADDR_W'(KICK_OFS) && regWdata[KICK_BIT]) |=> kickBusy);
endmodule

bind frac_clk_ctrl frac_clk_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZF_W(ZF_W),
  .KICK_OFS(KICK_OFS), .KICK_BIT(KICK_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
  .regWdata(regWdata), .clkEn(clkEn), .kickBusy(kickBusy),
  .periodEnd(periodEnd), .loadRatio(strobe.loadRatio),
  .activeZfc(activeZfc)
);

// File: tb/test_frac_clk_ctrl.sv
`timescale 1ns/1ps
module test_frac_clk_ctrl;
  localparam int CTRL_A = 'hE0;
  localparam int KICK_A = 'h04;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        clkEn;
  logic        kickBusy;

  int total = 0;
  int bad = 0;
  int benchCyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) benchCyc <= 0;
    else       benchCyc <= benchCyc + 1;
  end

  frac_clk_ctrl i_frac_clk_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .clkEn(clkEn), .kickBusy(kickBusy)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    regWr = 1'b1; regAddr = 12'(addr); regWdata = data;
    @(negedge clk);
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic doRead(input int addr, output logic [31:0] data);
    regRd = 1'b1; regAddr = 12'(addr);
    #1 data = regRdata;
    regRd = 1'b0;
  endtask

  task automatic measureWin(output int cnt);
    cnt = 0;
    while (benchCyc % 32 != 0) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      cnt += int'(clkEn);
      @(negedge clk);
    end
  endtask

  // trigger and poll until clear; checks R4 and R5
  task automatic kickAndWait(input string tag);
    logic [31:0] rv;
    int n;
    doWrite(KICK_A, 32'h8000_0000);
    doRead(KICK_A, rv);
    check(rv == 32'h8000_0000, {tag, " R4 busy readback"}, rv, 32'h8000_0000);
    n = 0;
    while (rv[31] && n < 40) begin
      @(negedge clk);
      n++;
      doRead(KICK_A, rv);
    end
    check(n <= 32, {tag, " R5 clear latency"}, n, 32);
    check(benchCyc % 32 == 0, {tag, " R5 clears at window start"}, benchCyc % 32, 0);
  endtask

  task automatic testReset();
    logic [31:0] rv;
    int c;
    doRead(CTRL_A, rv);
    check(rv == 0, "R1 code reg reset", rv, 0);
    doRead(KICK_A, rv);
    check(rv == 0, "R1 trigger reset", rv, 0);
    measureWin(c);
    check(c == 32, "R1 R2 full rate after reset", c, 32);
  endtask

  task automatic testRatio(input int z);
    logic [31:0] rv, wv;
    int c;
    wv = 32'hC300_0055 | (32'(z) << 8);
    doWrite(CTRL_A, wv);
    doRead(CTRL_A, rv);
    check(rv == wv, "R3 code reg readback", rv, wv);
    kickAndWait("ratio");
    measureWin(c);
    check(c == 32 - z, "R2 enables per window", c, 32 - z);
  endtask

  task automatic testNoKick();
    int c0, c1;
    measureWin(c0);
    doWrite(CTRL_A, 32'(31) << 8);
    measureWin(c1);
    check(c1 == c0, "R6 staged code without trigger", c1, c0);
  endtask

  task automatic testIgnored();
    logic [31:0] rv;
    int c0, c1;
    measureWin(c0);
    doWrite(KICK_A, 32'h7FFF_FFFF);
    doRead(KICK_A, rv);
    check(rv == 0, "R7 zero trigger write", rv, 0);
    measureWin(c1);
    check(c1 == c0, "R7 rate after zero trigger", c1, c0);
    // retrigger while pending
    doWrite(CTRL_A, 32'(9) << 8);
    measureWin(c0);
    doWrite(KICK_A, 32'h8000_0000);
    repeat (3) @(negedge clk);
    doWrite(KICK_A, 32'h8000_0000);
    doRead(KICK_A, rv);
    check(rv[31] == 1'b1, "R7 still pending after retrigger", rv, 32'h8000_0000);
    while (rv[31]) begin
      @(negedge clk);
      doRead(KICK_A, rv);
    end
    check(benchCyc % 32 == 0, "R7 retrigger keeps clearing point", benchCyc % 32, 0);
    check(benchCyc < c0 * 0 + 100000, "R7 sanity", benchCyc, 0);
    measureWin(c1);
    check(c1 == 23, "R7 R2 rate after retrigger", c1, 23);
  endtask

  task automatic testDecode();
    logic [31:0] rv;
    doRead('h10, rv);
    check(rv == 0, "R8 unmapped read", rv, 0);
    regAddr = 12'(CTRL_A);
    #1 rv = regRdata;
    check(rv == 0, "R8 read strobe low", rv, 0);
  endtask

  initial begin
    #1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNoKick();
    testRatio(31);
    testRatio(16);
    testRatio(5);
    testRatio(0);
    testIgnored();
    testDecode();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule